// File: doc/BRIEF.md
# Descriptor-completion interrupt combiner

This block sits beside a transfer engine that reports the completion of each transfer descriptor with a one-cycle pulse on its own bit of a done vector. The completions are stored in a sticky status word. Two software-programmed select masks then decide when the controller interrupt line is raised.

Descriptors selected in the "all" mask form a group. That group raises the interrupt only once every one of its members has completed, whatever the order and spacing of the completions. Descriptors selected in the "any" mask raise the interrupt individually: each completion is enough on its own.

Software acknowledges by writing ones to the status word, which clears those bits and re-arms the group condition. The interrupt is a registered level. It follows the status and mask registers one cycle later.

Top module: `irq_combiner`

## Requirements
- R1: After reset, both masks and the status word read 0 and `irq_o` is low.
- R2: A write at address 0 loads the all-group mask and a write at address 1 loads the any-group mask. Each reads back what was written. Writes to address 3 change no register, and reads of address 3 return 0.
- R3: A pulse on `done_i[i]` sets status bit i, which is read at address 2. The bit stays set until a write to address 2 with data bit i equal to 1. A 0 in the write data leaves the bit unchanged.
- R4: When a done pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: If any status bit selected by the any-group mask is set, `irq_o` is high in the following cycle.
- R6: If the all-group mask is non-zero and only part of its bits are set in status, and no any-group bit is set, `irq_o` is low in the following cycle. When the last group member completes, `irq_o` rises one cycle after its status bit sets.
- R7: An all-group mask of 0 never satisfies the group condition, even when every status bit is set.
- R8: A status bit selected by neither mask never causes `irq_o` to rise.
- R9: `irq_o` goes low one cycle after the status bits that caused it are cleared. Clearing any all-group bit re-arms the group, which then fires again only when all members are complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_i | input | NDESC | Per-descriptor completion pulses |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 all-mask, 1 any-mask, 2 status clear |
| wr_data | input | NDESC | Write data |
| rd_addr | input | 2 | Read address, same map as for writes |
| rd_data | output | NDESC | Combinational read data |
| irq_o | output | 1 | Level interrupt |

## Verification
On every cycle, the assertions check four things. Status bits are sticky, and a done pulse wins over a clear. The line is high in the cycle after an any-group bit is pending. The line stays low after a partial all-group, an empty all-group mask, or status holding only unselected bits.

Only the bench scenarios can show the rest. These are the mask readback, the ignored address, and the example ordering in which descriptors 1 and 2 complete first and descriptor 4 completes later. They also include the re-arming of the group after a partial clear. A long random run compares the line and the status word with a reference model.

// File: rtl/irq_combiner.sv
module irq_combiner #(
  parameter int NDESC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NDESC-1:0] done_i,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [NDESC-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [NDESC-1:0] rd_data,
  output logic             irq_o
);
  localparam logic [1:0] A_ALL = 2'd0;
  localparam logic [1:0] A_ANY = 2'd1;
  localparam logic [1:0] A_ST  = 2'd2;

  logic [NDESC-1:0] all_q, any_q, st_q, clr;
  logic             grp_hit, any_hit;

  assign clr     = (wr_en && wr_addr == A_ST) ? wr_data : '0;
  assign grp_hit = (all_q != '0) && ((st_q & all_q) == all_q);
  assign any_hit = |(st_q & any_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      all_q <= '0;
      any_q <= '0;
      st_q  <= '0;
      irq_o <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_ALL) all_q <= wr_data;
      if (wr_en && wr_addr == A_ANY) any_q <= wr_data;
      st_q  <= (st_q & ~clr) | done_i;
      irq_o <= grp_hit | any_hit;
    end
  end

  always_comb begin
    case (rd_addr)
      A_ALL:   rd_data = all_q;
      A_ANY:   rd_data = any_q;
      A_ST:    rd_data = st_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irq_combiner_chk.sv
module irq_combiner_chk #(
  parameter int NDESC = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NDESC-1:0] done_i,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [NDESC-1:0] wr_data,
  input logic [NDESC-1:0] all_q,
  input logic [NDESC-1:0] any_q,
  input logic [NDESC-1:0] st_q,
  input logic             irq_o
);
  logic [NDESC-1:0] clr_v;
  assign clr_v = (wr_en && wr_addr == 2'd2) ? wr_data : '0;

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(st_q) & ~$past(clr_v)) & ~st_q) == '0)); // R3
  AST_DONE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(done_i) & ~st_q) == '0)); // R4
  AST_ANY_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q & any_q) != '0) |=> irq_o); // R5
  AST_PARTIAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (all_q != '0 && (st_q & all_q) != all_q && (st_q & any_q) == '0) |=> !irq_o); // R6
  AST_EMPTY_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (all_q == '0 && (st_q & any_q) == '0) |=> !irq_o); // R7
  AST_NO_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q & (all_q | any_q)) == '0) |=> !irq_o); // R8
endmodule

bind irq_combiner irq_combiner_chk #(.NDESC(NDESC)) i_chk (
  .clk(clk), .rst_n(rst_n), .done_i(done_i), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .all_q(all_q), .any_q(any_q), .st_q(st_q), .irq_o(irq_o)
);

// File: tb/test_irq_combiner.sv
module test_irq_combiner;
  localparam int N = 32;
  localparam time CLK_P = 10;

  logic clk = 0, rst_n = 0, wr_en = 0, irq_o;
  logic [N-1:0] done_i = '0, wr_data = '0, rd_data;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  int tests = 0, fails = 0;
  logic [N-1:0] m_all = '0, m_any = '0, m_st = '0;
  logic m_irq = 0;

  irq_combiner #(.NDESC(N)) i_irq_combiner (.*);

  always #(CLK_P/2) clk = ~clk;

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish (act hung, exp done)");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic f_irq(logic [N-1:0] st, logic [N-1:0] a, logic [N-1:0] o);
    return ((a != '0) && ((st & a) == a)) || ((st & o) != '0);
  endfunction

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [N-1:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic cyc(string tag, logic [N-1:0] d, logic we, logic [1:0] a, logic [N-1:0] wd);
    logic [N-1:0] clr, v;
    done_i = d; wr_en = we; wr_addr = a; wr_data = wd;
    @(posedge clk);
    m_irq = f_irq(m_st, m_all, m_any);
    clr = (we && a == 2'd2) ? wd : '0;
    if (we && a == 2'd0) m_all = wd;
    if (we && a == 2'd1) m_any = wd;
    m_st = (m_st & ~clr) | d;
    @(negedge clk);
    done_i = '0; wr_en = 0;
    rd(2'd2, v); chk({tag, " status"}, v, m_st);
    chk({tag, " irq"}, {31'd0, irq_o}, {31'd0, m_irq});
  endtask

  initial begin
    logic [N-1:0] v;
    void'($urandom(32'd20251));
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(2'd0, v); chk("R1 all mask", v, '0);
    rd(2'd1, v); chk("R1 any mask", v, '0);
    rd(2'd2, v); chk("R1 status", v, '0);
    chk("R1 irq", {31'd0, irq_o}, '0);

    cyc("R2", '0, 1, 2'd0, 32'h0000_0016);
    cyc("R2", '0, 1, 2'd1, 32'h0000_0380);
    cyc("R2", '0, 1, 2'd3, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R2 all readback", v, 32'h16);
    rd(2'd1, v); chk("R2 any readback", v, 32'h380);
    rd(2'd3, v); chk("R2 addr3 reads zero", v, '0);

    cyc("R6 d1 d2", 32'h6, 0, 2'd0, '0);
    cyc("R6 idle", '0, 0, 2'd0, '0);
    chk("R6 partial quiet", {31'd0, irq_o}, '0);
    cyc("R6 d4", 32'h10, 0, 2'd0, '0);
    cyc("R6 fire", '0, 0, 2'd0, '0);
    chk("R6 group fires", {31'd0, irq_o}, 1);
    cyc("R9 clear d2", '0, 1, 2'd2, 32'h4);
    cyc("R9 drop", '0, 0, 2'd0, '0);
    chk("R9 irq drops", {31'd0, irq_o}, '0);
    cyc("R9 d2 again", 32'h4, 0, 2'd0, '0);
    cyc("R9 rearmed", '0, 0, 2'd0, '0);
    chk("R9 refire", {31'd0, irq_o}, 1);
    cyc("R3 zero write", '0, 1, 2'd2, 32'h0);
    rd(2'd2, v); chk("R3 zero keeps", v, 32'h16);
    cyc("R9 clr all", '0, 1, 2'd2, 32'h16);

    for (int k = 7; k <= 9; k++) begin
      cyc("R5 d", 32'h1 << k, 0, 2'd0, '0);
      cyc("R5 fire", '0, 1, 2'd2, 32'h1 << k);
      chk("R5 own event", {31'd0, irq_o}, 1);
      cyc("R5 drop", '0, 0, 2'd0, '0);
      chk("R5 drop", {31'd0, irq_o}, '0);
    end

    cyc("R8 unsel", 32'hFFFF_FC69, 0, 2'd0, '0);
    cyc("R8 unsel", '0, 0, 2'd0, '0);
    chk("R8 no irq", {31'd0, irq_o}, '0);
    cyc("R4 same cycle", 32'h1, 1, 2'd2, 32'h1);
    rd(2'd2, v); chk("R4 done wins", v[0], 1'b1);
    cyc("R7 masks", '0, 1, 2'd0, '0);
    cyc("R7 masks", '0, 1, 2'd1, '0);
    cyc("R7 all set", '1, 0, 2'd0, '0);
    cyc("R7 idle", '0, 0, 2'd0, '0);
    chk("R7 empty quiet", {31'd0, irq_o}, '0);
    cyc("R9 clr", '0, 1, 2'd2, '1);

    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] d, wd;
      logic we;
      logic [1:0] a;
      d  = ($urandom % 4 == 0) ? (32'h1 << ($urandom % N)) : '0;
      we = ($urandom % 5 == 0);
      a  = 2'($urandom % 4);
      wd = $urandom & $urandom;
      if (a == 2'd0) wd = wd & 32'h0000_00FF;
      cyc("R5 R6 random", d, we, a, wd);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule